// File: doc/BRIEF.md
# Shared Partial-Product Multi-Rate Interpolation Core

This block is the arithmetic core of a reconfigurable interpolation filter with a fixed 16-tap prototype. Each cycle it takes eight delayed input vectors, each holding one 4-sample input block. Vector `i` pairs with the coefficient pair at taps `2i` and `2i+1` to form a partial product vector. A tree of adders then folds these partial vectors together in three levels. The first level gives the phase sub-blocks of the factor-8 filter. The second level combines those into the factor-4 sub-blocks. The third level combines the factor-4 sub-blocks into the full factor-2 output block. All three results leave the block in the same cycle.

Two coefficient sets are built in as reset-time constants. A select input chooses one of them with a per-tap multiplexer. The choice applies to the vectors captured in the same cycle. No products are duplicated between the three rates: each adder level consumes only the sums of the level before it.

Top module: `rif_shared_au`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and every bit of `y8_o`, `y4_o` and `y2_o` is 0.
- R2: `out_valid_o` equals the value `in_valid_i` had at the previous rising clock edge, so there is exactly one cycle of latency.
- R3: When `in_valid_i` is low at a rising edge, `y8_o`, `y4_o` and `y2_o` keep their values, whatever `in_vec_i` and `filt_sel_i` do.
- R4: Filter 0 has taps h(k) = 9k − 70 and filter 1 has h(k) = ±(60 − 5k), with a plus sign for even k and a minus sign for odd k, for k = 0..15. `filt_sel_i` (0 or 1) picks the set used for the block captured at that same edge.
- R5: Sample `e` (0..3) of vector `i` (0..7) is the signed 8-bit field at bit `(i*4+e)*8` of `in_vec_i`. Multiplier unit `i` forms the products v_i[e]·h(2i+t) for t = 0,1.
- R6: Factor-8 sub-block `a` (0..3) has its element (e,t) at bit `((a*4+e)*2+t)*19` of `y8_o`. That element is the sum of v_i[e]·h(2i+t) over i ∈ {a, a+4}.
- R7: Factor-4 sub-block `b` (0..1) has its element (e,t) at bit `((b*4+e)*2+t)*19` of `y4_o`. It equals factor-8 sub-block b plus factor-8 sub-block b+2 at the same (e,t).
- R8: Element (e,t) at bit `(e*2+t)*19` of `y2_o` equals the sum of the two factor-4 sub-blocks at (e,t). When v_i[e] = x(4k+e−i), this is output 2(4k+e)+t of the zero-stuffed input convolved with the 16 taps.
- R9: All outputs are exact 19-bit two's-complement values with no wrap, including blocks of all −128 or all +127 samples.
- R10: All three output groups for one input block update at the same edge, from the same coefficient set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input vectors valid this cycle |
| filt_sel_i | input | 1 | Coefficient set select |
| in_vec_i | input | 256 | Eight 4-sample vectors of signed 8-bit samples |
| out_valid_o | output | 1 | Registered outputs updated last edge |
| y8_o | output | 608 | Four factor-8 phase sub-blocks, 8 × 19-bit each |
| y4_o | output | 304 | Two factor-4 phase sub-blocks, 8 × 19-bit each |
| y2_o | output | 152 | Factor-2 output block, 8 × 19-bit in time order |

## Verification
On every cycle, the assertions check the valid timing, the holding of outputs on idle cycles, and the nesting of the rates: each factor-4 element must equal its two factor-8 parents, and each factor-2 element must equal its two factor-4 parents. These checks cannot catch a wrong coefficient, a swapped vector or a wrong pairing in the first level. Only the bench's streams can show those, by comparing the factor-2 block with an independent zero-stuff-and-convolve model and the other groups with subset sums. The bench also covers filter switches between blocks and full-scale blocks.

// File: rtl/rif_pkg.sv
package rif_pkg;
  localparam int XW    = 8;
  localparam int CW    = 8;
  localparam int TAPS  = 16;
  localparam int PMIN  = 2;
  localparam int BLK   = 4;
  localparam int NFILT = 2;
  localparam int GUARD = 3;

  // reset-time coefficient sets, computed rather than tabulated
  function automatic int bank_coef(int f, int k);
    int mag;
    if (f == 0) return 9 * k - 70;
    mag = 60 - 5 * k;
    return ((k % 2) == 1) ? -mag : mag;
  endfunction
endpackage

// File: rtl/rif_coef_bank.sv
module rif_coef_bank #(
  parameter int TAPS  = 16,
  parameter int CW    = 8,
  parameter int NFILT = 2,
  localparam int SELW = (NFILT > 1) ? $clog2(NFILT) : 1
) (
  input  logic [SELW-1:0]    sel_i,
  output logic [TAPS*CW-1:0] coef_o
);
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [CW-1:0] row [NFILT];
    for (genvar f = 0; f < NFILT; f++) begin : g_filt
      assign row[f] = CW'(rif_pkg::bank_coef(f, k));
    end
    always_comb begin
      coef_o[k*CW +: CW] = row[0];
      for (int f = 1; f < NFILT; f++)
        if (int'(sel_i) == f) coef_o[k*CW +: CW] = row[f];
    end
  end
endmodule

// File: rtl/rif_mult_unit.sv
module rif_mult_unit #(
  parameter int BLK = 4,
  parameter int XW  = 8,
  parameter int CW  = 8,
  localparam int PW = XW + CW
) (
  input  logic [BLK*XW-1:0]   vec_i,
  input  logic [2*CW-1:0]     cpair_i,
  output logic [BLK*2*PW-1:0] prod_o
);
  for (genvar e = 0; e < BLK; e++) begin : g_samp
    for (genvar t = 0; t < 2; t++) begin : g_ph
      logic signed [XW-1:0] xs;
      logic signed [CW-1:0] cs;
      logic signed [PW-1:0] pr;
      assign xs = vec_i[e*XW +: XW];
      assign cs = cpair_i[t*CW +: CW];
      assign pr = PW'(xs) * PW'(cs);
      assign prod_o[(e*2+t)*PW +: PW] = pr;
    end
  end
endmodule

// File: rtl/rif_pair_add.sv
module rif_pair_add #(
  parameter int N  = 8,
  parameter int IW = 16,
  parameter int OW = 19
) (
  input  logic [N*IW-1:0] a_i,
  input  logic [N*IW-1:0] b_i,
  output logic [N*OW-1:0] s_o
);
  for (genvar j = 0; j < N; j++) begin : g_el
    logic signed [IW-1:0] av, bv;
    logic signed [OW-1:0] sv;
    assign av = a_i[j*IW +: IW];
    assign bv = b_i[j*IW +: IW];
    assign sv = OW'(av) + OW'(bv);
    assign s_o[j*OW +: OW] = sv;
  end
endmodule

// File: rtl/rif_shared_au.sv
module rif_shared_au #(
  parameter int TAPS  = 16,
  parameter int PMIN  = 2,
  parameter int BLK   = 4,
  parameter int XW    = 8,
  parameter int CW    = 8,
  parameter int NFILT = 2,
  parameter int GUARD = 3,
  localparam int SELW = (NFILT > 1) ? $clog2(NFILT) : 1,
  localparam int NMU  = TAPS / PMIN,
  localparam int PW   = XW + CW,
  localparam int SW   = PW + GUARD,
  localparam int ELEM = BLK * PMIN,
  localparam int N8   = NMU / 2,
  localparam int N4   = NMU / 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic [SELW-1:0]          filt_sel_i,
  input  logic [NMU*BLK*XW-1:0]    in_vec_i,
  output logic                     out_valid_o,
  output logic [N8*ELEM*SW-1:0]    y8_o,
  output logic [N4*ELEM*SW-1:0]    y4_o,
  output logic [ELEM*SW-1:0]       y2_o
);
  logic [TAPS*CW-1:0] coef;
  logic [ELEM*PW-1:0] zv [NMU];
  logic [ELEM*SW-1:0] l1 [N8];
  logic [ELEM*SW-1:0] l2 [N4];
  logic [ELEM*SW-1:0] l3;

  rif_coef_bank #(.TAPS(TAPS), .CW(CW), .NFILT(NFILT)) u_bank (
    .sel_i (filt_sel_i),
    .coef_o(coef)
  );

  // one multiplier unit per coefficient pair
  for (genvar i = 0; i < NMU; i++) begin : g_mu
    rif_mult_unit #(.BLK(BLK), .XW(XW), .CW(CW)) u_mu (
      .vec_i  (in_vec_i[i*BLK*XW +: BLK*XW]),
      .cpair_i(coef[i*PMIN*CW +: 2*CW]),
      .prod_o (zv[i])
    );
  end

  // level 1: tap pairs 8 apart -> factor-8 phases
  for (genvar a = 0; a < N8; a++) begin : g_l1
    rif_pair_add #(.N(ELEM), .IW(PW), .OW(SW)) u_add (
      .a_i(zv[a]), .b_i(zv[a+N8]), .s_o(l1[a])
    );
  end

  // level 2: reuse factor-8 sums -> factor-4 phases
  for (genvar b = 0; b < N4; b++) begin : g_l2
    rif_pair_add #(.N(ELEM), .IW(SW), .OW(SW)) u_add (
      .a_i(l1[b]), .b_i(l1[b+N4]), .s_o(l2[b])
    );
  end

  // level 3: reuse factor-4 sums -> factor-2 block
  rif_pair_add #(.N(ELEM), .IW(SW), .OW(SW)) u_l3 (
    .a_i(l2[0]), .b_i(l2[1]), .s_o(l3)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      y8_o        <= '0;
      y4_o        <= '0;
      y2_o        <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        for (int a = 0; a < N8; a++) y8_o[a*ELEM*SW +: ELEM*SW] <= l1[a];
        for (int b = 0; b < N4; b++) y4_o[b*ELEM*SW +: ELEM*SW] <= l2[b];
        y2_o <= l3;
      end
    end
  end
endmodule

// File: rtl/rif_shared_au_chk.sv
module rif_shared_au_chk #(
  parameter int N8   = 4,
  parameter int N4   = 2,
  parameter int ELEM = 8,
  parameter int SW   = 19
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic                  out_valid_o,
  input logic [N8*ELEM*SW-1:0] y8_o,
  input logic [N4*ELEM*SW-1:0] y4_o,
  input logic [ELEM*SW-1:0]    y2_o
);
  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R2
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(y8_o) && $stable(y4_o) && $stable(y2_o)));

  for (genvar b = 0; b < N4; b++) begin : g_r7
    for (genvar j = 0; j < ELEM; j++) begin : g_el
      logic [SW-1:0] s4;
      assign s4 = y8_o[(b*ELEM+j)*SW +: SW] + y8_o[((b+N4)*ELEM+j)*SW +: SW];
      // R7
      f4_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        y4_o[(b*ELEM+j)*SW +: SW] == s4);
    end
  end

  for (genvar j = 0; j < ELEM; j++) begin : g_r8
    logic [SW-1:0] s2;
    assign s2 = y4_o[j*SW +: SW] + y4_o[(ELEM+j)*SW +: SW];
    // R8
    f2_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      y2_o[j*SW +: SW] == s2);
  end
endmodule

bind rif_shared_au rif_shared_au_chk #(
  .N8(N8), .N4(N4), .ELEM(ELEM), .SW(SW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .y8_o       (y8_o),
  .y4_o       (y4_o),
  .y2_o       (y2_o)
);

// File: tb/rif_shared_au_test.sv
module rif_shared_au_test;
  localparam int CLK_NS = 10;
  localparam int XW = 8, BLK = 4, NMU = 8, SW = 19, ELEM = 8;
  localparam int VW = NMU * BLK * XW;
  localparam int Y8W = 4 * ELEM * SW, Y4W = 2 * ELEM * SW, Y2W = ELEM * SW;
  localparam int NB = 400;

  logic clk_i = 1'b0, rst_ni = 1'b0, in_valid_i = 1'b0, filt_sel_i = 1'b0;
  logic [VW-1:0] in_vec_i = '0;
  logic out_valid_o;
  logic [Y8W-1:0] y8_o;
  logic [Y4W-1:0] y4_o;
  logic [Y2W-1:0] y2_o;

  int n_run = 0, n_fail = 0;
  int xs [NB*BLK];
  int sel_of [NB];

  always #(CLK_NS/2) clk_i = ~clk_i;

  rif_shared_au uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .filt_sel_i(filt_sel_i), .in_vec_i(in_vec_i),
    .out_valid_o(out_valid_o), .y8_o(y8_o), .y4_o(y4_o), .y2_o(y2_o)
  );

  function automatic int hc(int f, int k);
    if (f == 0) return 9 * k - 70;
    return ((k % 2) == 1) ? -(60 - 5 * k) : (60 - 5 * k);
  endfunction

  function automatic int gx(int j);
    if (j < 0) return 0;
    return xs[j];
  endfunction

  function automatic int ustuff(int j);
    if (j < 0 || (j % 2) == 1) return 0;
    return gx(j / 2);
  endfunction

  function automatic int fld(logic [Y8W-1:0] bus, int idx);
    logic [SW-1:0] v;
    v = bus[idx*SW +: SW];
    return int'($signed(v));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_block(int k);
    for (int i = 0; i < NMU; i++)
      for (int e = 0; e < BLK; e++)
        in_vec_i[(i*BLK+e)*XW +: XW] = XW'(gx(k*BLK + e - i));
    filt_sel_i = sel_of[k][0];
    in_valid_i = 1'b1;
  endtask

  // compare all three groups of block k
  task automatic check_block(int k, string tag);
    int f, act, exp, ba8, be8, ba4, be4, ba2, be2;
    bit ok8, ok4, ok2;
    logic [Y8W-1:0] p4, p2;
    f = sel_of[k];
    p4 = {{(Y8W-Y4W){1'b0}}, y4_o};
    p2 = {{(Y8W-Y2W){1'b0}}, y2_o};
    ok8 = 1; ok4 = 1; ok2 = 1;
    ba8 = 0; be8 = 0; ba4 = 0; be4 = 0; ba2 = 0; be2 = 0;
    for (int e = 0; e < BLK; e++)
      for (int t = 0; t < 2; t++) begin
        for (int a = 0; a < 4; a++) begin
          exp = 0;
          for (int i = a; i < NMU; i += 4) exp += hc(f, 2*i+t) * gx(k*BLK + e - i);
          act = fld(y8_o, (a*BLK+e)*2+t);
          if (act != exp && ok8) begin ok8 = 0; ba8 = act; be8 = exp; end
        end
        for (int b = 0; b < 2; b++) begin
          exp = 0;
          for (int i = b; i < NMU; i += 2) exp += hc(f, 2*i+t) * gx(k*BLK + e - i);
          act = fld(p4, (b*BLK+e)*2+t);
          if (act != exp && ok4) begin ok4 = 0; ba4 = act; be4 = exp; end
        end
        exp = 0;
        for (int m = 0; m < 16; m++) exp += hc(f, m) * ustuff(2*(k*BLK+e) + t - m);
        act = fld(p2, e*2+t);
        if (act != exp && ok2) begin ok2 = 0; ba2 = act; be2 = exp; end
      end
    chk(ok8, {"R5 R6 factor-8 ", tag}, ba8, be8);
    chk(ok4, {"R7 factor-4 ", tag}, ba4, be4);
    chk(ok2, {"R8 factor-2 ", tag}, ba2, be2);
    chk(ok8 && ok4 && ok2, {"R10 same-edge groups ", tag}, int'(ok8 && ok4 && ok2), 1);
    chk(out_valid_o == 1'b1, {"R2 valid ", tag}, int'(out_valid_o), 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [Y8W-1:0] s8;
    logic [Y4W-1:0] s4;
    logic [Y2W-1:0] s2;
    for (int j = 0; j < NB*BLK; j++) begin
      int blk = j / BLK;
      if (blk >= 20 && blk < 24) xs[j] = -128;
      else if (blk >= 40 && blk < 44) xs[j] = 127;
      else if (blk >= 60 && blk < 64) xs[j] = (j % 2) ? 127 : -128;
      else xs[j] = int'($urandom_range(255)) - 128;
    end
    for (int k = 0; k < NB; k++) sel_of[k] = (k < 100) ? (k / 7) % 2 : int'($urandom_range(1));
    sel_of[21] = 0; sel_of[22] = 1; sel_of[41] = 1; sel_of[42] = 0;

    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk(out_valid_o == 1'b0, "R1 valid in reset", int'(out_valid_o), 0);
    chk(y8_o == '0 && y4_o == '0, "R1 y8/y4 zero in reset", int'(|y8_o || |y4_o), 0);
    chk(y2_o == '0, "R1 y2 zero in reset", int'(|y2_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int k = 0; k < NB; k++) begin
      @(negedge clk_i);
      drive_block(k);
      @(posedge clk_i);
      #1;
      if (k >= 20 && k < 24) check_block(k, "R9 all -128");
      else if (k >= 40 && k < 44) check_block(k, "R9 all +127");
      else if (k > 0 && sel_of[k] != sel_of[k-1]) check_block(k, "R4 filter switch");
      else check_block(k, "stream");

      if (k == 150 || k == 300) begin
        s8 = y8_o; s4 = y4_o; s2 = y2_o;
        for (int idle = 0; idle < 3; idle++) begin
          @(negedge clk_i);
          in_valid_i = 1'b0;
          filt_sel_i = ~filt_sel_i;
          for (int w = 0; w < VW / 32; w++) in_vec_i[w*32 +: 32] = $urandom;
          @(posedge clk_i);
          #1;
          chk(out_valid_o == 1'b0, "R2 valid low after idle", int'(out_valid_o), 0);
          chk(y8_o == s8 && y4_o == s4 && y2_o == s2, "R3 hold on idle",
              int'(y2_o[SW-1:0]), int'(s2[SW-1:0]));
        end
      end
    end

    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk(out_valid_o == 1'b0, "R2 valid drops", int'(out_valid_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule